// File: doc/BRIEF.md
# Fetch/Store Bus Arbiter with Write Yield

This block lets two bus masters share one Wishbone slave port. Master 0 is the instruction-fetch path and master 1 is the data path. A single grant bit selects which master drives the slave. In the normal case, the master that owns the bus keeps it for as long as its request (`cyc`) stays high. The bus changes hands only when the owner lets go.

A fetch stream that runs from a slow memory-mapped flash never lets go on its own, so a pending store could wait without bound. To stop this, the arbiter adds a yield rule. The rule applies while the fetch master owns the bus and the flash bridge is in memory-mapped mode. In that state, a data-master write request takes the grant away on the next clock edge. The arbiter also drives the same yield condition out to the flash bridge, so the bridge can close its open read burst.

Data-master reads never force a yield. They wait until the fetch master releases the bus in the normal way.

Top module: `fetch_store_arbiter`

## Requirements
- R1: After reset, `grant_o` is 0, meaning the fetch master owns the bus.
- R2: The owning master keeps the grant on every edge where its `cyc` stays high, unless the R4 yield applies.
- R3: When `grant_o` is 0, `m0_cyc` is low, `m1_cyc` is high and the R7 hold does not apply, `grant_o` becomes 1 after the next rising edge.
- R4: When `grant_o` is 0 and `m0_cyc` is high, the grant still moves to 1 on the next edge if `m1_cyc`, `m1_we` and `flash_mmap_i` are all high and the R7 hold does not apply.
- R5: A data-master read (`m1_we` low) does not move the grant away from a requesting fetch master. Neither does a data-master write while `flash_mmap_i` is low.
- R6: When `grant_o` is 1 and `m1_cyc` drops, the grant returns to 0 on the next edge if `m0_cyc` is high. If `m0_cyc` is low, the grant stays at 1.
- R7: The grant does not change on an edge in which `s_ack` or `s_err` is high.
- R8: `yield_o` equals `m1_cyc & m1_we & flash_mmap_i` in the same cycle, whoever holds the grant.
- R9: `s_cyc`, `s_stb`, `s_we`, `s_adr`, `s_dat_w` and `s_sel` come from the granted master in the same cycle.
- R10: `s_ack`, `s_err` and `s_dat_r` reach only the granted master. The other master sees ack 0, err 0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_mmap_i | input | 1 | Flash bridge is in memory-mapped (fetch) mode |
| m0_cyc | input | 1 | Fetch master cycle / request |
| m0_stb | input | 1 | Fetch master strobe |
| m0_we | input | 1 | Fetch master write enable |
| m0_adr | input | AW | Fetch master address |
| m0_dat_w | input | DW | Fetch master write data |
| m0_sel | input | DW/8 | Fetch master byte selects |
| m0_ack | output | 1 | Acknowledge to fetch master |
| m0_err | output | 1 | Error to fetch master |
| m0_dat_r | output | DW | Read data to fetch master |
| m1_cyc | input | 1 | Data master cycle / request |
| m1_stb | input | 1 | Data master strobe |
| m1_we | input | 1 | Data master write enable |
| m1_adr | input | AW | Data master address |
| m1_dat_w | input | DW | Data master write data |
| m1_sel | input | DW/8 | Data master byte selects |
| m1_ack | output | 1 | Acknowledge to data master |
| m1_err | output | 1 | Error to data master |
| m1_dat_r | output | DW | Read data to data master |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_adr | output | AW | Slave address |
| s_dat_w | output | DW | Slave write data |
| s_sel | output | DW/8 | Slave byte selects |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error |
| s_dat_r | input | DW | Slave read data |
| grant_o | output | 1 | Current owner: 0 = fetch, 1 = data |
| yield_o | output | 1 | Write-yield request to the flash bridge |

## Verification
A yield-qualifying store can arrive in the same cycle that the slave acknowledges the fetch master. In that cycle, grant hand-over and acknowledge routing compete for the same edge. The bench provokes this by holding a fetch request, a data write and memory-mapped mode while it pulses `s_ack`, and later `s_err`.

Two results are judged. First, the acknowledge must go to the fetch master alone in that cycle. Second, the grant must stay put across that edge and move only on the next quiet edge. `yield_o` is checked in the same cycle so that the bridge-facing signal is seen to rise independently of the grant.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  typedef enum logic {
    OWN_FETCH = 1'b0,
    OWN_DATA  = 1'b1
  } owner_e;

  // Write-yield condition presented to the flash bridge.
  function automatic logic write_yield(input logic cyc1, input logic we1,
                                       input logic mmap);
    return cyc1 & we1 & mmap;
  endfunction

  // Next owner of the shared slave port.
  function automatic owner_e pick_owner(input owner_e cur, input logic req0,
                                        input logic req1, input logic yld,
                                        input logic busy);
    owner_e nxt;
    nxt = cur;
    if (!busy) begin
      if (cur == OWN_FETCH) begin
        if (req1 && (!req0 || yld)) nxt = OWN_DATA;
      end else begin
        if (!req1 && req0) nxt = OWN_FETCH;
      end
    end
    return nxt;
  endfunction

endpackage

// File: rtl/fsa_grant_ctrl.sv
module fsa_grant_ctrl
  import fsa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req0,
  input  logic   req1,
  input  logic   we1,
  input  logic   mmap,
  input  logic   bus_ack,
  input  logic   bus_err,
  output owner_e owner,
  output logic   yield_o
);

  logic   yield_w;
  logic   busy_w;
  owner_e owner_q;
  owner_e owner_d;

  assign yield_w = write_yield(req1, we1, mmap);
  assign busy_w  = bus_ack | bus_err;
  assign owner_d = pick_owner(owner_q, req0, req1, yield_w, busy_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_FETCH;
    else        owner_q <= owner_d;
  end

  assign owner   = owner_q;
  assign yield_o = yield_w;

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_FETCH && req0 && !yield_w) |=> owner_q == OWN_FETCH); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_DATA && req1) |=> owner_q == OWN_DATA); // R2
  AST_YIELD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_FETCH && req1 && we1 && mmap && !busy_w) |=> owner_q == OWN_DATA); // R4
  AST_NO_SWITCH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(owner_q)); // R7
  AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_DATA && !req1 && req0 && !busy_w) |=> owner_q == OWN_FETCH); // R6

endmodule

// File: rtl/fsa_bus_mux.sv
module fsa_bus_mux
  import fsa_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  owner_e        owner,
  input  logic          m0_cyc,
  input  logic          m0_stb,
  input  logic          m0_we,
  input  logic [AW-1:0] m0_adr,
  input  logic [DW-1:0] m0_dat_w,
  input  logic [SW-1:0] m0_sel,
  output logic          m0_ack,
  output logic          m0_err,
  output logic [DW-1:0] m0_dat_r,
  input  logic          m1_cyc,
  input  logic          m1_stb,
  input  logic          m1_we,
  input  logic [AW-1:0] m1_adr,
  input  logic [DW-1:0] m1_dat_w,
  input  logic [SW-1:0] m1_sel,
  output logic          m1_ack,
  output logic          m1_err,
  output logic [DW-1:0] m1_dat_r,
  output logic          s_cyc,
  output logic          s_stb,
  output logic          s_we,
  output logic [AW-1:0] s_adr,
  output logic [DW-1:0] s_dat_w,
  output logic [SW-1:0] s_sel,
  input  logic          s_ack,
  input  logic          s_err,
  input  logic [DW-1:0] s_dat_r
);

  localparam int NM = 2;

  logic          ack_a [NM];
  logic          err_a [NM];
  logic [DW-1:0] dat_a [NM];

  always_comb begin
    if (owner == OWN_DATA) begin
      s_cyc = m1_cyc; s_stb = m1_stb; s_we = m1_we;
      s_adr = m1_adr; s_dat_w = m1_dat_w; s_sel = m1_sel;
    end else begin
      s_cyc = m0_cyc; s_stb = m0_stb; s_we = m0_we;
      s_adr = m0_adr; s_dat_w = m0_dat_w; s_sel = m0_sel;
    end
  end

  for (genvar k = 0; k < NM; k++) begin : g_ret
    logic mine;
    assign mine     = (owner == owner_e'(k));
    assign ack_a[k] = s_ack & mine;
    assign err_a[k] = s_err & mine;
    assign dat_a[k] = mine ? s_dat_r : '0;
  end

  assign m0_ack = ack_a[0]; assign m0_err = err_a[0]; assign m0_dat_r = dat_a[0];
  assign m1_ack = ack_a[1]; assign m1_err = err_a[1]; assign m1_dat_r = dat_a[1];

  AST_RET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m0_ack | m0_err, m1_ack | m1_err})); // R10
  AST_SLAVE_ADR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (s_adr == m0_adr) || (s_adr == m1_adr)); // R9

endmodule

// File: rtl/fetch_store_arbiter.sv
module fetch_store_arbiter
  import fsa_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flash_mmap_i,
  input  logic          m0_cyc,
  input  logic          m0_stb,
  input  logic          m0_we,
  input  logic [AW-1:0] m0_adr,
  input  logic [DW-1:0] m0_dat_w,
  input  logic [SW-1:0] m0_sel,
  output logic          m0_ack,
  output logic          m0_err,
  output logic [DW-1:0] m0_dat_r,
  input  logic          m1_cyc,
  input  logic          m1_stb,
  input  logic          m1_we,
  input  logic [AW-1:0] m1_adr,
  input  logic [DW-1:0] m1_dat_w,
  input  logic [SW-1:0] m1_sel,
  output logic          m1_ack,
  output logic          m1_err,
  output logic [DW-1:0] m1_dat_r,
  output logic          s_cyc,
  output logic          s_stb,
  output logic          s_we,
  output logic [AW-1:0] s_adr,
  output logic [DW-1:0] s_dat_w,
  output logic [SW-1:0] s_sel,
  input  logic          s_ack,
  input  logic          s_err,
  input  logic [DW-1:0] s_dat_r,
  output logic          grant_o,
  output logic          yield_o
);

  owner_e owner_w;

  fsa_grant_ctrl u_grant (
    .clk(clk), .rst_n(rst_n), .req0(m0_cyc), .req1(m1_cyc), .we1(m1_we),
    .mmap(flash_mmap_i), .bus_ack(s_ack), .bus_err(s_err),
    .owner(owner_w), .yield_o(yield_o)
  );

  fsa_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .owner(owner_w),
    .m0_cyc(m0_cyc), .m0_stb(m0_stb), .m0_we(m0_we), .m0_adr(m0_adr),
    .m0_dat_w(m0_dat_w), .m0_sel(m0_sel), .m0_ack(m0_ack), .m0_err(m0_err),
    .m0_dat_r(m0_dat_r),
    .m1_cyc(m1_cyc), .m1_stb(m1_stb), .m1_we(m1_we), .m1_adr(m1_adr),
    .m1_dat_w(m1_dat_w), .m1_sel(m1_sel), .m1_ack(m1_ack), .m1_err(m1_err),
    .m1_dat_r(m1_dat_r),
    .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_w(s_dat_w), .s_sel(s_sel), .s_ack(s_ack), .s_err(s_err),
    .s_dat_r(s_dat_r)
  );

  assign grant_o = owner_w;

  AST_RESET_OWNER: assert property (@(posedge clk) $rose(rst_n) |-> grant_o == 1'b0); // R1
  AST_YIELD_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_cyc && !m1_we) |-> !yield_o); // R5

endmodule

// File: tb/fetch_store_arbiter_bench.sv
module fetch_store_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flash_mmap_i = 1'b0;
  logic m0_cyc = 0, m0_stb = 0, m0_we = 0;
  logic [AW-1:0] m0_adr = 32'h1000_0040;
  logic [DW-1:0] m0_dat_w = 32'h0000_0A0A;
  logic [SW-1:0] m0_sel = 4'hF;
  logic m0_ack, m0_err;
  logic [DW-1:0] m0_dat_r;
  logic m1_cyc = 0, m1_stb = 0, m1_we = 0;
  logic [AW-1:0] m1_adr = 32'h3000_0010;
  logic [DW-1:0] m1_dat_w = 32'h1234_CDEF;
  logic [SW-1:0] m1_sel = 4'h3;
  logic m1_ack, m1_err;
  logic [DW-1:0] m1_dat_r;
  logic s_cyc, s_stb, s_we;
  logic [AW-1:0] s_adr;
  logic [DW-1:0] s_dat_w;
  logic [SW-1:0] s_sel;
  logic s_ack = 0, s_err = 0;
  logic [DW-1:0] s_dat_r = 32'hC0DE_5A5A;
  logic grant_o, yield_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic model_g = 1'b0;

  typedef struct { logic g; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_store_arbiter #(.AW(AW), .DW(DW)) u_fetch_store_arbiter (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare grant after each edge with the queued expectation.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(grant_o === e.g, e.tag, grant_o, e.g);
    end
  end

  // Driver: apply one cycle of stimulus, check combinational paths, queue grant.
  task automatic drive(input logic c0, input logic c1, input logic w1,
                       input logic mm, input logic ak, input logic er,
                       input string tag);
    logic nx;
    @(negedge clk);
    m0_cyc = c0; m0_stb = c0; m1_cyc = c1; m1_stb = c1; m1_we = w1;
    flash_mmap_i = mm; s_ack = ak; s_err = er;
    #1;
    check(yield_o === (c1 & w1 & mm), "R8 yield_o", yield_o, c1 & w1 & mm);
    check(s_adr === (model_g ? m1_adr : m0_adr), "R9 s_adr", s_adr,
          model_g ? m1_adr : m0_adr);
    check(s_cyc === (model_g ? c1 : c0) && s_we === (model_g ? w1 : m0_we) &&
          s_sel === (model_g ? m1_sel : m0_sel) &&
          s_dat_w === (model_g ? m1_dat_w : m0_dat_w), "R9 slave fwd", s_cyc, model_g ? c1 : c0);
    check(m0_ack === (ak & !model_g) && m1_ack === (ak & model_g), "R10 ack route",
          {m1_ack, m0_ack}, {ak & model_g, ak & !model_g});
    check(m0_err === (er & !model_g) && m1_err === (er & model_g), "R10 err route",
          {m1_err, m0_err}, {er & model_g, er & !model_g});
    check(m0_dat_r === (model_g ? 32'h0 : s_dat_r) && m1_dat_r === (model_g ? s_dat_r : 32'h0),
          "R10 dat_r route", model_g ? m1_dat_r : m0_dat_r, s_dat_r);
    // Expected next owner, per R2..R7.
    if (ak || er) nx = model_g;                                  // R7
    else if (!model_g) nx = (c1 && (!c0 || (w1 && mm))) ? 1'b1 : 1'b0;  // R3/R4/R5
    else nx = (!c1 && c0) ? 1'b0 : 1'b1;                         // R6/R2
    sb_q.push_back('{g: nx, tag: tag});
    model_g = nx;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(grant_o === 1'b0, "R1 reset grant", grant_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(grant_o === 1'b0, "R1 grant after release", grant_o, 0);
    drive(0, 0, 0, 0, 0, 0, "R2 idle stays fetch");
    drive(1, 0, 0, 1, 0, 0, "R2 fetch holds");
    drive(1, 1, 0, 1, 0, 0, "R5 data read no yield");
    drive(1, 1, 0, 1, 0, 0, "R5 data read still waits");
    drive(1, 1, 1, 0, 0, 0, "R5 write without mmap no yield");
    drive(1, 1, 1, 1, 1, 0, "R7 ack blocks yield");
    drive(1, 1, 1, 1, 0, 1, "R7 err blocks yield");
    drive(1, 1, 1, 1, 0, 0, "R4 write yield takes grant");
    drive(1, 1, 1, 1, 1, 0, "R2 data holds with ack");
    drive(1, 1, 0, 1, 0, 0, "R2 data holds back-to-back");
    drive(1, 0, 0, 1, 0, 1, "R7 err blocks return");
    drive(1, 0, 0, 1, 0, 0, "R6 return to fetch");
    drive(0, 1, 0, 0, 0, 0, "R3 free bus to data");
    drive(0, 0, 0, 0, 0, 0, "R6 stays data when idle");
    drive(0, 1, 1, 1, 0, 0, "R2 data keeps grant");
    drive(1, 0, 0, 0, 0, 0, "R6 fetch regains");
    drive(0, 0, 0, 0, 0, 0, "R2 idle fetch");
    @(negedge clk);
    m0_cyc = 0; m1_cyc = 0; m0_stb = 0; m1_stb = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule